// File: doc/BRIEF.md
# SPI Burst Exchange Engine

This block is the shifting core of an SPI master. Software loads 32-bit words into a transmit FIFO, programs a burst length in bits and then sets an exchange bit. The engine drives the serial clock, the data-out line and an active-low chip-select for exactly the programmed number of bits, and packs the sampled data-in bits into 32-bit words in a receive FIFO. When the burst length is not a multiple of 32, the leftover bits travel first. They come from the low end of the first transmit word and land right-aligned in the first receive word. Every later word carries a full 32 bits.

Clock division is left outside. An external divider pulses `shift_tick`, and each pulse advances the serial clock by one half-period. The serial clock runs in mode 0: it idles low, data-out is set up before each rising edge and data-in is sampled on each rising edge. Software reaches the block through a small register port with four word addresses: transmit data, receive data, control and status.

Top module: `spi_burst_xchg`

## Requirements
- R1: The burst-length field, control register (address 2) bits 17:8, holds the burst size in bits minus one. A burst produces exactly that value plus one rising edges of `sclk`, and `sclk` changes only in the cycle after a `shift_tick` pulse.
- R2: A write to address 0 pushes one 32-bit word into the transmit FIFO. A write while the FIFO already holds TX_DEPTH words is dropped.
- R3: With a programmed value L, the first transmit word supplies only its low (L mod 32)+1 bits. These bits are shifted out first, and each following word then supplies 32 bits.
- R4: Every word is shifted most significant bit first. `mosi` holds a bit before the rising `sclk` edge that samples it and moves to the next bit after the falling edge. `sclk` rests low.
- R5: A burst starts only on a control write that has bit 0 (enable) and bit 1 (exchange) both set while the engine is idle. A write with exchange set but enable clear starts nothing. Every control write during a burst is ignored. Control bit 1 reads as 1 for as long as the burst is in progress.
- R6: Status bit 0 (done) is set in the same clock in which `cs_n` returns high. At that edge control bit 1 reads back as 0 again.
- R7: Writing 1 to status (address 3) bit 0 or bit 1 clears that flag. If a flag is set in the same cycle as the clearing write, the set wins.
- R8: A read of address 1 returns the oldest receive word and removes it, and a read of an empty receive FIFO returns zero. The first word of a burst holds the leftover (L mod 32)+1 bits right-aligned with zeros above them. Each later group of 32 sampled bits forms one word, with the first sampled bit as its MSB.
- R9: A receive word that completes while the receive FIFO is full, with no read of address 1 in the same cycle, sets status bit 1 (overflow) and is lost. If such a read does occur in that cycle, the word is stored.
- R10: Once the transmit FIFO runs empty during a burst, every remaining bit is sent as 0.
- R11: `cs_n` falls at the clock edge that starts a burst. It stays low until the first `shift_tick` after the last falling `sclk` edge, which is one extra half-period. Outside the shifting phase `mosi` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_tick | input | 1 | One-cycle pulse from the external divider, one per SCLK half-period |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO at address 1) |
| reg_addr | input | 2 | Word address: 0 TX data, 1 RX data, 2 control, 3 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address |
| sclk | output | 1 | Serial clock, mode 0 |
| cs_n | output | 1 | Chip-select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Two pairs of events can land on the same clock edge. In the first, a receive word completes while the receive FIFO is full and software reads address 1 in that very cycle. In the second, done is raised at the end of a burst while software writes 1 to clear it. The bench predicts both cycles from its behavioural model: the rising tick that finishes a receive word, and the tick that ends the tail half-period. It places the read or the clearing write exactly there. Afterwards it judges the outcome from the receive FIFO contents and the overflow flag (the first word kept, the next one lost) and from done remaining set.

// File: rtl/spi_burst_xchg.sv
module spi_burst_xchg #(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int LEN_W    = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        shift_tick,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sclk,
  output logic        cs_n,
  output logic        mosi,
  input  logic        miso
);

  localparam int TAW = (TX_DEPTH > 1) ? $clog2(TX_DEPTH) : 1;
  localparam int RAW = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1;
  localparam int TCW = $clog2(TX_DEPTH + 1);
  localparam int RCW = $clog2(RX_DEPTH + 1);
  localparam logic [TCW-1:0] TX_FULL = TCW'(TX_DEPTH);
  localparam logic [RCW-1:0] RX_FULL = RCW'(RX_DEPTH);
  localparam logic [TAW-1:0] TX_LAST = TAW'(TX_DEPTH - 1);
  localparam logic [RAW-1:0] RX_LAST = RAW'(RX_DEPTH - 1);
  localparam logic [1:0] A_TX = 2'd0, A_RX = 2'd1, A_CTRL = 2'd2, A_STAT = 2'd3;

  logic [31:0]    tx_mem [TX_DEPTH];
  logic [31:0]    rx_mem [RX_DEPTH];
  logic [TAW-1:0] tx_wp, tx_rp;
  logic [RAW-1:0] rx_wp, rx_rp;
  logic [TCW-1:0] tx_cnt;
  logic [RCW-1:0] rx_cnt;

  logic             en_q, run_q, tail_q, done_q, ovf_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W:0]   bits_left;
  logic [5:0]       wcnt;
  logic [31:0]      tx_sr;
  logic [30:0]      rx_sr;
  logic [31:0]      ctrl_rd;

  wire busy      = run_q | tail_q;
  wire ctrl_wr   = reg_wr && reg_addr == A_CTRL && !busy;
  wire stat_wr   = reg_wr && reg_addr == A_STAT;
  wire start     = ctrl_wr && reg_wdata[0] && reg_wdata[1];
  wire rise      = run_q && shift_tick && !sclk;
  wire fall      = run_q && shift_tick && sclk;
  wire last_fall = fall && bits_left == (LEN_W+1)'(1);
  wire finish    = tail_q && shift_tick;
  wire word_end  = fall && !last_fall && wcnt == 6'd1;

  wire [LEN_W-1:0] new_len = reg_wdata[8 +: LEN_W];
  wire [5:0]       first_n = {1'b0, new_len[4:0]} + 6'd1;

  wire        tx_push = reg_wr && reg_addr == A_TX && tx_cnt != TX_FULL;
  wire        tx_pop  = (start || word_end) && tx_cnt != '0;
  wire [31:0] tx_word = (tx_cnt != '0) ? tx_mem[tx_rp] : 32'd0;

  wire [31:0] rx_word = {rx_sr, miso};
  wire        rx_push = rise && wcnt == 6'd1;
  wire        rx_pop  = reg_rd && reg_addr == A_RX && rx_cnt != '0;
  wire        rx_take = rx_push && (rx_cnt != RX_FULL || rx_pop);
  wire        rx_drop = rx_push && !rx_take;

  assign mosi = run_q & tx_sr[31];

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[0] = en_q;
    ctrl_rd[1] = busy;
    ctrl_rd[8 +: LEN_W] = len_q;
  end

  always_comb begin
    case (reg_addr)
      A_RX:    reg_rdata = (rx_cnt != '0) ? rx_mem[rx_rp] : 32'd0;
      A_CTRL:  reg_rdata = ctrl_rd;
      A_STAT:  reg_rdata = {30'd0, ovf_q, done_q};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= reg_wdata;
    if (rx_take) rx_mem[rx_wp] <= rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= (tx_wp == TX_LAST) ? '0 : tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= (tx_rp == TX_LAST) ? '0 : tx_rp + 1'b1;
      if (rx_take) rx_wp <= (rx_wp == RX_LAST) ? '0 : rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= (rx_rp == RX_LAST) ? '0 : rx_rp + 1'b1;
      tx_cnt <= tx_cnt + TCW'(tx_push) - TCW'(tx_pop);
      rx_cnt <= rx_cnt + RCW'(rx_take) - RCW'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; len_q <= '0; run_q <= 1'b0; tail_q <= 1'b0;
      done_q <= 1'b0; ovf_q <= 1'b0; sclk <= 1'b0; cs_n <= 1'b1;
      bits_left <= '0; wcnt <= '0; tx_sr <= '0; rx_sr <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q  <= reg_wdata[0];
        len_q <= new_len;
      end
      if (start) begin
        run_q     <= 1'b1;
        cs_n      <= 1'b0;
        bits_left <= {1'b0, new_len} + (LEN_W+1)'(1);
        wcnt      <= first_n;
        tx_sr     <= tx_word << (6'd32 - first_n);
        rx_sr     <= '0;
      end else if (rise) begin
        sclk  <= 1'b1;
        rx_sr <= rx_push ? '0 : rx_word[30:0];
      end else if (fall) begin
        sclk      <= 1'b0;
        bits_left <= bits_left - (LEN_W+1)'(1);
        if (last_fall) begin
          run_q  <= 1'b0;
          tail_q <= 1'b1;
        end else if (wcnt == 6'd1) begin
          wcnt  <= 6'd32;
          tx_sr <= tx_word;
        end else begin
          wcnt  <= wcnt - 6'd1;
          tx_sr <= {tx_sr[30:0], 1'b0};
        end
      end else if (finish) begin
        tail_q <= 1'b0;
        cs_n   <= 1'b1;
      end
      done_q <= finish  | (done_q & ~(stat_wr & reg_wdata[0]));
      ovf_q  <= rx_drop | (ovf_q  & ~(stat_wr & reg_wdata[1]));
    end
  end

endmodule

// File: rtl/spi_burst_xchg_chk.sv
module spi_burst_xchg_chk #(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         shift_tick,
  input logic                         sclk,
  input logic                         cs_n,
  input logic                         reg_wr,
  input logic [1:0]                   reg_addr,
  input logic [1:0]                   reg_wdata,
  input logic                         done_q,
  input logic                         ovf_q,
  input logic [$clog2(RX_DEPTH+1)-1:0] rx_cnt,
  input logic [$clog2(TX_DEPTH+1)-1:0] tx_cnt
);

  localparam int RCW = $clog2(RX_DEPTH + 1);
  localparam int TCW = $clog2(TX_DEPTH + 1);
  localparam logic [RCW-1:0] RX_FULL = RCW'(RX_DEPTH);
  localparam logic [TCW-1:0] TX_FULL = TCW'(TX_DEPTH);

  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_sclk_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != $past(sclk)) |-> $past(shift_tick));

  p_cs_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(reg_wr && reg_addr == 2'd2 && reg_wdata == 2'b11));

  p_done_at_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $rose(cs_n));

  p_ovf_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> (rx_cnt == RX_FULL) && $past(rx_cnt == RX_FULL));

  p_tx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= TX_FULL);

endmodule

bind spi_burst_xchg spi_burst_xchg_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_tick(shift_tick), .sclk(sclk), .cs_n(cs_n),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata[1:0]),
  .done_q(done_q), .ovf_q(ovf_q), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt)
);

// File: tb/sim_spi_burst_xchg.sv
module sim_spi_burst_xchg;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic shift_tick = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0, miso = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic sclk, cs_n, mosi;

  always #5 clk = ~clk;

  spi_burst_xchg #(.TX_DEPTH(DEPTH), .RX_DEPTH(DEPTH), .LEN_W(10)) u0 (
    .clk(clk), .rst_n(rst_n), .shift_tick(shift_tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  int errors = 0, checks = 0, rises = 0;
  bit finished = 0;

  bit m_run, m_tail, m_en, m_done, m_ovf, m_sclk, m_cs_n = 1'b1;
  int m_len, rcnt, rtgt;
  logic [31:0] racc;
  bit mbits[$];
  logic [31:0] txq[$], rxq[$];

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd1: return (rxq.size() > 0) ? rxq[0] : 32'd0;
      2'd2: return (32'(m_len) << 8) | (32'(m_run | m_tail) << 1) | 32'(m_en);
      2'd3: return {30'd0, m_ovf, m_done};
      default: return 32'd0;
    endcase
  endfunction

  task automatic build_bits();
    int n = (m_len % 32) + 1;
    int rem = m_len + 1 - n;
    logic [31:0] w;
    mbits.delete();
    w = (txq.size() > 0) ? txq.pop_front() : 32'd0;
    for (int b = n - 1; b >= 0; b--) mbits.push_back(w[b]);
    while (rem > 0) begin
      w = (txq.size() > 0) ? txq.pop_front() : 32'd0;
      for (int b = 31; b >= 0; b--) mbits.push_back(w[b]);
      rem -= 32;
    end
  endtask

  task automatic step(input bit tk, input bit wr, input bit rd, input logic [1:0] a, input logic [31:0] wd);
    bit was_run = m_run, was_tail = m_tail, dset = 0, oset = 0;
    if (rd && a == 2'd1 && rxq.size() > 0) void'(rxq.pop_front());
    if (tk && was_run) begin
      if (!m_sclk) begin
        m_sclk = 1;
        racc = {racc[30:0], miso};
        rcnt++;
        if (rcnt == rtgt) begin
          if (rxq.size() < DEPTH) rxq.push_back(racc); else oset = 1;
          racc = 0; rcnt = 0; rtgt = 32;
        end
      end else begin
        m_sclk = 0;
        void'(mbits.pop_front());
        if (mbits.size() == 0) begin m_run = 0; m_tail = 1; end
      end
    end else if (tk && was_tail) begin
      m_tail = 0; m_cs_n = 1; dset = 1;
    end
    if (wr && a == 2'd0 && txq.size() < DEPTH) txq.push_back(wd);
    if (wr && a == 2'd2 && !(was_run || was_tail)) begin
      m_en = wd[0];
      m_len = int'(wd[17:8]);
      if (wd[0] && wd[1]) begin
        build_bits();
        m_run = 1; m_cs_n = 0;
        racc = 0; rcnt = 0; rtgt = (m_len % 32) + 1;
      end
    end
    if (wr && a == 2'd3) begin
      if (wd[0]) m_done = 0;
      if (wd[1]) m_ovf = 0;
    end
    if (dset) m_done = 1;
    if (oset) m_ovf = 1;
  endtask

  task automatic cyc(input bit tk, input bit wr, input bit rd, input logic [1:0] a, input logic [31:0] wd);
    logic old_sclk;
    bit em;
    @(negedge clk);
    shift_tick = tk; reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    miso = 1'($urandom);
    #1;
    if (rd) chk(reg_rdata, exp_rd(a), a == 2'd1 ? "R8 rx read" : (a == 2'd2 ? "R5 ctrl read" : "R7 status read"));
    step(tk, wr, rd, a, wd);
    old_sclk = sclk;
    @(posedge clk);
    #1;
    if (!old_sclk && sclk) rises++;
    em = m_run && mbits.size() > 0 && mbits[0];
    chk({29'd0, sclk, cs_n, mosi}, {29'd0, m_sclk, m_cs_n, em}, "R1/R3/R4/R10/R11 serial");
  endtask

  task automatic push_tx(input logic [31:0] w);
    cyc(0, 1, 0, 2'd0, w);
  endtask

  task automatic wr_ctrl(input bit en, input bit x, input int len);
    cyc(0, 1, 0, 2'd2, (32'(len) << 8) | (32'(x) << 1) | 32'(en));
  endtask

  task automatic rd_reg(input logic [1:0] a);
    cyc(0, 0, 1, a, 0);
  endtask

  task automatic drain_rx();
    while (rxq.size() > 0) rd_reg(2'd1);
    rd_reg(2'd1);
  endtask

  task automatic run_burst(input int tdiv, input bit pop_trick, input bit clr_trick, input bit midwrite);
    bit popped = 0;
    for (int i = 0; i < 5000 && (m_run || m_tail); i++) begin
      bit tk = (i % tdiv) == tdiv - 1;
      if (pop_trick && !popped && m_run && !m_sclk && tk && rcnt + 1 == rtgt && rxq.size() == DEPTH) begin
        popped = 1;
        cyc(tk, 0, 1, 2'd1, 0);
      end else if (clr_trick && m_tail && tk)
        cyc(tk, 1, 0, 2'd3, 32'd1);
      else if (midwrite && i == 10)
        cyc(tk, 1, 0, 2'd2, (32'd3 << 8) | 32'd3);
      else
        cyc(tk, 0, 0, 2'd0, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk({29'd0, sclk, cs_n, mosi}, 32'b010, "R11 reset idle");
    rd_reg(2'd2);
    rd_reg(2'd3);
    chk(reg_rdata, 32'd0, "R7 status zero after reset");

    // partial leading byte then one full word
    push_tx(32'h0000_00A5); push_tx(32'hDEAD_BEEF);
    wr_ctrl(1, 1, 39);
    rd_reg(2'd2);
    chk(reg_rdata & 32'h2, 32'h2, "R5 exchange bit reads busy");
    rises = 0;
    run_burst(2, 0, 0, 0);
    chk(32'(rises), 32'd40, "R1 rising edges for 40-bit burst");
    rd_reg(2'd3);
    chk(reg_rdata, 32'd1, "R6 done set");
    rd_reg(2'd2);
    chk(reg_rdata & 32'h2, 32'h0, "R6 exchange bit cleared");
    drain_rx();
    chk(reg_rdata, 32'd0, "R8 empty rx read is zero");
    cyc(0, 1, 0, 2'd3, 32'd1);
    rd_reg(2'd3);
    chk(reg_rdata, 32'd0, "R7 done cleared by write-one");

    // TX underrun: two full words, one supplied
    push_tx(32'h8000_0001);
    wr_ctrl(1, 1, 63);
    rises = 0;
    run_burst(1, 0, 0, 0);
    chk(32'(rises), 32'd64, "R10 full length with zeros after underrun");
    drain_rx();
    cyc(0, 1, 0, 2'd3, 32'd3);

    // exchange without enable
    wr_ctrl(0, 1, 7);
    for (int k = 0; k < 6; k++) cyc(1, 0, 0, 2'd0, 0);
    chk({31'd0, cs_n}, 32'd1, "R5 no start without enable");
    rd_reg(2'd2);
    chk(reg_rdata, 32'h0000_0700, "R5 ctrl readback after idle write");

    // control write during a burst is ignored
    push_tx(32'h0000_C3A5);
    wr_ctrl(1, 1, 15);
    rises = 0;
    run_burst(3, 0, 0, 1);
    chk(32'(rises), 32'd16, "R5 mid-burst write ignored");
    rd_reg(2'd2);
    chk(reg_rdata, 32'h0000_0F01, "R5 length kept");
    drain_rx();
    cyc(0, 1, 0, 2'd3, 32'd3);

    // overflow with one same-cycle pop rescue
    push_tx(32'h1111_1111); push_tx(32'h2222_2222); push_tx(32'h3333_3333); push_tx(32'h4444_4444);
    wr_ctrl(1, 1, 191);
    run_burst(1, 1, 0, 0);
    rd_reg(2'd3);
    chk(reg_rdata, 32'd3, "R9 overflow after pop-rescued word");
    chk(32'(rxq.size()), 32'd4, "R9 model rx depth");
    drain_rx();
    cyc(0, 1, 0, 2'd3, 32'd2);
    rd_reg(2'd3);
    chk(reg_rdata, 32'd1, "R7 overflow cleared alone");
    cyc(0, 1, 0, 2'd3, 32'd1);

    // done raised in the same cycle as its clear
    push_tx(32'h0000_005A);
    wr_ctrl(1, 1, 7);
    run_burst(2, 0, 1, 0);
    rd_reg(2'd3);
    chk(reg_rdata, 32'd1, "R7 set wins over clear");
    drain_rx();
    cyc(0, 1, 0, 2'd3, 32'd1);

    // TX overfill: fifth word dropped
    for (int k = 0; k < 5; k++) push_tx(32'hF0F0_0000 | 32'(k + 1));
    chk(32'(txq.size()), 32'd4, "R2 model tx depth");
    wr_ctrl(1, 1, 159);
    run_burst(2, 0, 0, 0);
    drain_rx();

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule